// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock synchronous SRAM with registered inputs and registered outputs. It is built around a small array, by default 16 words of 36 bits split into four 9-bit byte lanes. An access starts when either of two address strobes is seen while the chip is selected. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. After a start, a burst-advance input steps a 2-bit counter that supplies the two low address bits. The upper address bits stay fixed, so a burst covers the four words of an aligned block in either linear or interleaved order.

Read data leaves through a three-stage pipeline: input register, synchronous array read, output register. A separate data-out bus carries the data, and a valid flag stands in for an output driver. Deselect turns the output off one stage sooner than read data would arrive. The output enable and the sleep input mask the valid flag without waiting for a clock edge. Sleep also blocks every new operation while the array keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst` is high at a rising edge, the pipeline clears. After reset, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read start captured at rising edge n drives `rvalid`=1 and the addressed word on `rdata` after edge n+2. Each accepted advance adds one more word on the following edge.
- R3: With `order_linear`=1 at the start, advance k (k=1,2,3) addresses low bits (start+k) mod 4. Bits above bit 1 never change within a burst, so the burst wraps inside its 4-word block.
- R4: With `order_linear`=0, the default, the low two bits of advance k are start XOR k.
- R5: A write with `wr_byte_n`=0 and `wr_all_n`=1 updates only the lanes i whose `lane_sel_n[i]`=0, where lane i is `wdata[9i+8:9i]`. The other lanes keep their old contents.
- R6: A write with `wr_all_n`=0 updates all four lanes, whatever `wr_byte_n` and `lane_sel_n` are.
- R7: A start that has `start_cpu_n`=0 is always a read, even if `start_ctl_n` is also low. The write controls have no effect in that cycle. With only `start_ctl_n`=0, the start is a write when `wr_all_n`=0 or `wr_byte_n`=0, and a read otherwise.
- R8: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A strobe while the chip is not selected is a deselect: it does no access and it ends the active burst.
- R9: A deselect captured at edge n forces `rvalid` low after edge n+1. This cancels a read word that was due to appear after that edge.
- R10: A new address may be started on every cycle. Back-to-back single reads return one word per cycle, in the order they were issued.
- R11: While `sleep`=1, `rvalid` is 0 at once, without a clock edge. Strobes, advances and writes sampled during sleep have no effect, and the array contents are kept.
- R12: While `out_en_n`=1, `rvalid` is 0 at once. The pipeline keeps running, and a pending word shows again as soon as `out_en_n` returns to 0.
- R13: A cycle with no strobe and no advance is a hold: the burst position is kept. An advance when no burst is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address loaded on a start |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| start_cpu_n | input | 1 | Processor-side address strobe; starts a read |
| start_ctl_n | input | 1 | Controller-side address strobe; starts a read or a write |
| step_n | input | 1 | Burst advance, active low |
| order_linear | input | 1 | 1 selects linear burst order, 0 selects interleaved order; latched at the start |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Output enable, active low, takes effect without a clock edge |
| sleep | input | 1 | Sleep, active high, takes effect without a clock edge |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data |
| rvalid | output | 1 | Read data valid, standing in for the output driver |

## Verification
The bench starts a burst from every one of the 16 addresses in both orders. A counter that carried into the upper bits or used the wrong order would return a word from the wrong block. Every byte-select mask is written over the old data. This catches a design that writes unselected lanes, or one that lets the byte selects beat a global write. A read is issued just before a deselect through each of the three select pins; a design that pipelines the turn-off as deeply as the data would still show the cancelled word. Writes issued under the processor-side strobe and during sleep are read back, which exposes a design that lets either of them change the array.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2,
    OP_DSEL = 2'd3
  } sram_op_e;

  // low two address bits for burst position idx
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] idx,
                                           input logic       linear);
    return linear ? (base + idx) : (base ^ idx);
  endfunction

endpackage

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_linear,
  input  logic              advance,
  input  logic              drop,
  output logic [ADDR_W-1:0] next_addr,
  output logic              active
);
  localparam int HI = ADDR_W - 1;

  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        idx_q, idx_n;
  logic              lin_q, lin_n;
  logic              act_q;

  always_comb begin
    base_n    = load ? load_addr : base_q;
    idx_n     = load ? 2'd0 : idx_q + 2'd1;
    lin_n     = load ? load_linear : lin_q;
    // upper bits come from the base only: the burst wraps in its block
    next_addr = {base_n[HI:2], burst_low(base_n[1:0], idx_n, lin_n)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
      lin_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (load || advance) begin
        base_q <= base_n;
        idx_q  <= idx_n;
        lin_q  <= lin_n;
      end
      if (load)      act_q <= 1'b1;
      else if (drop) act_q <= 1'b0;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/sbsram_in_stage.sv
module sbsram_in_stage
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    start_cpu_n,
  input  logic                    start_ctl_n,
  input  logic                    step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    burst_act,
  input  logic [ADDR_W-1:0]       burst_addr,
  output logic                    load,
  output logic                    advance,
  output logic                    drop,
  output sram_op_e                s1_op,
  output logic [ADDR_W-1:0]       s1_addr,
  output logic [LANES*LANE_W-1:0] s1_data,
  output logic [LANES-1:0]        s1_mask
);
  localparam int DATA_W = LANES * LANE_W;

  logic             chip_sel, any_strobe, awake, wr_req, start_wr;
  sram_op_e         op_n;
  logic [LANES-1:0] mask_n;

  always_comb begin
    chip_sel   = !cs1_n && cs2 && !cs3_n;
    any_strobe = !start_cpu_n || !start_ctl_n;
    awake      = !sleep;
    wr_req     = !wr_all_n || !wr_byte_n;
    drop       = awake && any_strobe && !chip_sel;
    load       = awake && any_strobe && chip_sel;
    // the processor-side strobe forces a read
    start_wr   = load && start_cpu_n && wr_req;
    advance    = awake && !any_strobe && !step_n && burst_act;

    if (drop)         op_n = OP_DSEL;
    else if (load)    op_n = start_wr ? OP_WR : OP_RD;
    else if (advance) op_n = wr_req ? OP_WR : OP_RD;
    else              op_n = OP_IDLE;

    if (!wr_all_n)       mask_n = '1;
    else if (!wr_byte_n) mask_n = ~lane_sel_n;
    else                 mask_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_data <= '0;
      s1_mask <= '0;
    end else begin
      s1_op <= op_n;
      if (op_n == OP_RD || op_n == OP_WR) s1_addr <= burst_addr;
      s1_data <= wdata[DATA_W-1:0];
      s1_mask <= (op_n == OP_WR) ? mask_n : '0;
    end
  end

endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one simple-port memory per lane, synchronous read
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      lane_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/sbsram_out_stage.sv
module sbsram_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_now,
  input  logic              kill,
  input  logic [DATA_W-1:0] arr_q,
  input  logic              out_en_n,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              vld_q
);
  logic              s2_q;
  logic [DATA_W-1:0] s3_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_q    <= 1'b0;
      vld_q   <= 1'b0;
      s3_data <= '0;
    end else begin
      s2_q  <= rd_now;
      // a deselect in the input stage shuts the output one stage early
      vld_q <= s2_q && !kill;
      if (s2_q) s3_data <= arr_q;
    end
  end

  assign rdata  = s3_data;
  assign rvalid = vld_q && !out_en_n && !sleep;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs1_n,
  input  logic                    cs2,
  input  logic                    cs3_n,
  input  logic                    start_cpu_n,
  input  logic                    start_ctl_n,
  input  logic                    step_n,
  input  logic                    order_linear,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    out_en_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, advance, drop, burst_act, vld_q;
  logic [ADDR_W-1:0] burst_addr, s1_addr;
  sram_op_e          s1_op;
  logic [DATA_W-1:0] s1_data, arr_q;
  logic [LANES-1:0]  s1_mask;

  sbsram_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .load(load), .load_addr(addr),
    .load_linear(order_linear), .advance(advance), .drop(drop),
    .next_addr(burst_addr), .active(burst_act)
  );

  sbsram_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
    .sleep(sleep), .wdata(wdata), .burst_act(burst_act), .burst_addr(burst_addr),
    .load(load), .advance(advance), .drop(drop),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_data(s1_data), .s1_mask(s1_mask)
  );

  sbsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .wr_en(s1_op == OP_WR), .wr_mask(s1_mask), .addr(s1_addr),
    .wdata(s1_data), .rdata(arr_q)
  );

  sbsram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd_now(s1_op == OP_RD), .kill(s1_op == OP_DSEL),
    .arr_q(arr_q), .out_en_n(out_en_n), .sleep(sleep),
    .rdata(rdata), .rvalid(rvalid), .vld_q(vld_q)
  );

endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              start_cpu_n,
  input logic              start_ctl_n,
  input logic              step_n,
  input logic              wr_all_n,
  input logic              wr_byte_n,
  input logic              sleep,
  input logic              out_en_n,
  input logic              rvalid,
  input logic              vld_q,
  input logic              burst_act,
  input logic [LANES-1:0]  s1_mask,
  input logic [ADDR_W-1:0] s1_addr
);
  logic [1:0] age;
  logic       sel, strobe, rd_go, desel_go, gw_go, step_go;

  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  assign sel      = !cs1_n && cs2 && !cs3_n;
  assign strobe   = !start_cpu_n || !start_ctl_n;
  assign rd_go    = !sleep && sel && strobe && (!start_cpu_n || (wr_all_n && wr_byte_n));
  assign desel_go = !sleep && strobe && !sel;
  assign gw_go    = !sleep && sel && start_cpu_n && !start_ctl_n && !wr_all_n;
  assign step_go  = !sleep && !strobe && !step_n && burst_act;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !vld_q);

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(rd_go, 3) && !$past(desel_go, 2)) |-> vld_q);

  // R9
  early_off_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(desel_go, 2)) |-> !vld_q);

  // R6
  global_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd1 && $past(gw_go)) |-> (s1_mask == '1));

  // R3
  block_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(step_go)) |-> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  // R11
  sleep_mask_chk: assert property (@(posedge clk) disable iff (rst) sleep |-> !rvalid);

  // R12
  oe_mask_chk: assert property (@(posedge clk) disable iff (rst) out_en_n |-> !rvalid);

endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_u (
  .clk(clk), .rst(rst), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
  .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
  .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .sleep(sleep), .out_en_n(out_en_n),
  .rvalid(rvalid), .vld_q(vld_q), .burst_act(burst_act),
  .s1_mask(s1_mask), .s1_addr(s1_addr)
);

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
  localparam int AW = 4, NL = 4, LW = 9, DW = NL * LW, DEPTH = 1 << AW;
  localparam int SLOTS = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, cs1_n, cs2, cs3_n, start_cpu_n, start_ctl_n, step_n;
  logic          order_linear, wr_all_n, wr_byte_n, out_en_n, sleep;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_sel_n;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .order_linear(order_linear), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic done = 1'b0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic          exp_v [SLOTS];
  logic [DW-1:0] exp_d [SLOTS];
  string         exp_r [SLOTS];
  logic [AW-1:0] b_base;
  logic [1:0]    b_idx;
  logic          b_lin;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // one clock; outputs compared at the following falling edge
  task automatic tick();
    logic ev;
    string tag;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    ev  = exp_v[cyc] && !sleep && !out_en_n;
    tag = (exp_r[cyc] == "") ? "R2" : exp_r[cyc];
    check(tag, {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, ev});
    if (ev) check(tag, rdata, exp_d[cyc]);
  endtask

  task automatic idle();
    addr = '0; start_cpu_n = 1; start_ctl_n = 1; step_n = 1;
    wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1; wdata = '0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return {4'(a), 8'(salt), 24'hA5C3E1} ^ {12'h0, 4'(a), 4'(salt), 16'h0};
  endfunction

  function automatic logic [AW-1:0] bnext();
    logic [1:0] lo;
    b_idx = b_idx + 2'd1;
    lo = b_lin ? b_base[1:0] + b_idx : b_base[1:0] ^ b_idx;
    return {b_base[AW-1:2], lo};
  endfunction

  task automatic rd(input int a, input bit cpu, input bit ctl, input bit junk_wr, input string tag);
    addr = AW'(a); start_cpu_n = !cpu; start_ctl_n = !ctl;
    if (junk_wr) begin wr_all_n = 0; wr_byte_n = 0; lane_sel_n = '0; end
    wdata = ~ref_mem[a];
    exp_v[cyc+3] = 1; exp_d[cyc+3] = ref_mem[a]; exp_r[cyc+3] = tag;
    b_base = AW'(a); b_idx = 0; b_lin = order_linear;
    tick(); idle();
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input bit gw, input bit bwe, input logic [NL-1:0] lsn);
    addr = AW'(a); start_ctl_n = 0; wr_all_n = !gw; wr_byte_n = !bwe; lane_sel_n = lsn; wdata = d;
    for (int i = 0; i < NL; i++)
      if (gw || (bwe && !lsn[i])) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
    b_base = AW'(a); b_idx = 0; b_lin = order_linear;
    tick(); idle();
  endtask

  task automatic stp_rd(input string tag);
    logic [AW-1:0] a;
    a = bnext();
    step_n = 0;
    exp_v[cyc+3] = 1; exp_d[cyc+3] = ref_mem[a]; exp_r[cyc+3] = tag;
    tick(); idle();
  endtask

  task automatic stp_wr(input logic [DW-1:0] d);
    logic [AW-1:0] a;
    a = bnext();
    step_n = 0; wr_all_n = 0; wdata = d; ref_mem[a] = d;
    tick(); idle();
  endtask

  task automatic dsel(input int v);
    cs1_n = (v == 0); cs2 = (v != 1); cs3_n = (v == 2);
    start_ctl_n = 0; addr = 4'd6;
    exp_v[cyc+2] = 0; exp_r[cyc+2] = "R9";
    exp_r[cyc+3] = "R8";
    tick();
    cs1_n = 0; cs2 = 1; cs3_n = 0; idle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin exp_v[i] = 0; exp_d[i] = '0; exp_r[i] = ""; end
    idle(); cs1_n = 0; cs2 = 1; cs3_n = 0; order_linear = 0; out_en_n = 0; sleep = 0;
    rst = 1;
    tick(); tick();
    // R1 reset state
    check("R1", {{(DW-1){1'b0}}, rvalid}, '0);
    check("R1", rdata, '0);
    rst = 0;
    tick();

    // fill with global writes, one new address every cycle
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 1), 1, 0, '1);
    // R10 back-to-back single reads
    for (int a = 0; a < DEPTH; a++) rd(a, 1, 0, 0, "R10");
    repeat (3) tick();

    // R3 / R4 every start address in both orders
    for (int lin = 0; lin < 2; lin++) begin
      order_linear = lin[0];
      for (int a = 0; a < DEPTH; a++) begin
        rd(a, 0, 1, 0, lin ? "R3" : "R4");
        for (int k = 1; k < 4; k++) stp_rd(lin ? "R3" : "R4");
      end
    end
    order_linear = 0;
    repeat (3) tick();

    // R5 every lane mask over inverted data
    for (int m = 0; m < DEPTH; m++) wr(m, ~ref_mem[m], 0, 1, NL'(m));
    for (int m = 0; m < DEPTH; m++) rd(m, 1, 0, 0, "R5");
    // R6 global write beats byte controls
    wr(3, pat(3, 7), 1, 0, '1);
    wr(5, pat(5, 8), 1, 1, 4'b1010);
    rd(3, 0, 1, 0, "R6");
    rd(5, 0, 1, 0, "R6");
    repeat (3) tick();

    // R7 processor strobe ignores write controls; it wins over the controller strobe
    rd(7, 1, 0, 1, "R7");
    rd(7, 1, 1, 1, "R7");
    rd(7, 0, 1, 0, "R7");
    repeat (3) tick();

    // R3 linear write burst wrapping in its block, then read back
    order_linear = 1;
    wr(9, pat(9, 20), 1, 0, '1);
    for (int k = 1; k < 4; k++) stp_wr(pat(k, 21));
    rd(9, 0, 1, 0, "R3");
    for (int k = 1; k < 4; k++) stp_rd("R3");
    order_linear = 0;
    repeat (3) tick();

    // R13 hold cycle inside a burst keeps its position
    rd(12, 0, 1, 0, "R13");
    exp_r[cyc+3] = "R13";
    tick();
    stp_rd("R13");
    stp_rd("R13");
    repeat (3) tick();

    // R9 / R8 deselect through each select pin
    for (int v = 0; v < 3; v++) begin
      rd(1, 1, 0, 0, "R9");
      rd(2, 1, 0, 0, "R9");
      dsel(v);
      // R13 advance with no active burst is ignored
      step_n = 0; exp_r[cyc+3] = "R13";
      tick(); idle();
      repeat (3) tick();
    end

    // R11 sleep masks output and blocks a write
    rd(4, 1, 0, 0, "R11");
    sleep = 1; start_ctl_n = 0; addr = 4'd4; wr_all_n = 0; wdata = ~ref_mem[4];
    exp_r[cyc+2] = "R11"; exp_r[cyc+3] = "R11";
    tick(); idle(); tick();
    sleep = 0; #1;
    check("R11", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, 1'b1});
    check("R11", rdata, ref_mem[4]);
    sleep = 1; #1;
    check("R11", {{(DW-1){1'b0}}, rvalid}, '0);
    sleep = 0;
    tick();
    rd(4, 1, 0, 0, "R11");
    repeat (3) tick();

    // R12 output enable masks without stopping the pipeline
    rd(6, 1, 0, 0, "R12");
    out_en_n = 1;
    tick(); tick();
    out_en_n = 0; #1;
    check("R12", {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, 1'b1});
    check("R12", rdata, ref_mem[6]);
    out_en_n = 1; #1;
    check("R12", {{(DW-1){1'b0}}, rvalid}, '0);
    out_en_n = 0;
    repeat (4) tick();

    done = 1;
    summary();
    $finish;
  end

endmodule